// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM rated for 70 ns access. The host presents one word at a time: it raises a request with an address, a write flag and write data, and the block accepts it on a clock edge where it reports itself ready. The block then produces the active-low chip-enable, output-enable and write-enable strobes, the address, and the outgoing data together with an enable for the external tri-state driver. A read finishes with a single-cycle valid strobe that carries the captured word.

Every analog limit is given in nanoseconds as a parameter, along with the clock period. The package converts each limit into whole clock cycles. It divides and rounds up, and no count falls below one cycle. Writes are terminated by the write strobe and keep output-enable low throughout. For that reason the write-enable pulse covers the memory's output turn-off time plus the data setup time. The block's own drivers switch on only after the memory has had time to release the bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, all three strobes are high (inactive), the data drive enable is low, `req_ready` is high and `rd_valid` is low.
- R2: A read holds chip-enable and output-enable low, with write-enable high, for exactly RD cycles. RD is the rounded-up quotient of max(read cycle 70 ns, address access 70 ns) by the clock period, which gives 9 at 8 ns.
- R3: The read word is sampled on the clock edge that raises chip-enable. On that same edge `rd_valid` goes high for exactly one cycle, and `rd_data` holds the word stored at the address.
- R4: A write holds chip-enable, output-enable and write-enable low together for exactly WL cycles, and all three rise on the same edge. WL is the largest of ceil(50 ns), ceil(30+25 ns), ceil(60 ns) and ceil(25 ns)+ceil(30 ns), all in clock periods. This gives 8 at 8 ns.
- R5: The data drive enable rises exactly DV = ceil(25 ns / period) cycles after write-enable falls (4 at 8 ns). It falls on the edge that raises write-enable, and it is never high while write-enable is high.
- R6: During a write, `mem_dq_out` carries the accepted write data, and a later read of that address returns it.
- R7: Between the end of one access and the start of the next, chip-enable stays high for at least two cycles. After a read this is one turnaround cycle plus the idle cycle. After a write it is a recovery of max(1, ceil(70 ns) - WL - 1) cycles plus the idle cycle.
- R8: `req_ready` is high only while the block is idle with chip-enable high. Address, data and write-flag changes without `req_valid`, or while the block is busy, start no access.
- R9: While chip-enable is low, `mem_addr` and, for a write, `mem_dq_out` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle strobe, read data present |
| rd_data | output | DATA_W | Captured read word |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Enable for the data tri-state driver |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The bench builds the block with its default values: an 8 ns clock, 16-bit address and data, and the 70 ns speed grade. With these values the read window is 9 cycles, the write pulse 8, the drive delay 4 and the write recovery 1. At these values the write pulse is set by address setup and by the split between drive delay and data setup, not by the bare pulse minimum, so both of those terms are tested. The memory model returns a corrupted word until the last cycle of the read window, so a capture taken one cycle early is caught. Random back-to-back mixes of reads and writes cover every turnaround pairing.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RGAP,
        ST_WLOW,
        ST_WREC
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } mem_ctl_t;

    localparam mem_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // Nanoseconds to whole cycles, rounded up, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC  = 9,
    parameter int unsigned DRV_CYC = 4,
    parameter int unsigned WEL_CYC = 8,
    parameter int unsigned REC_CYC = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     req_write,
    output logic     req_ready,
    output logic     accept,
    output logic     last_rd,
    output mem_ctl_t ctl
);

    localparam int unsigned CNT_MAX = max2(max2(RD_CYC, WEL_CYC), REC_CYC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign last_rd   = (state == ST_READ) && (cnt == CNT_W'(RD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ctl   <= CTL_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cnt      <= '0;
                        ctl.ce_n <= 1'b0;
                        ctl.oe_n <= 1'b0;
                        ctl.we_n <= !req_write;
                        ctl.drive <= 1'b0;
                        state    <= req_write ? ST_WLOW : ST_READ;
                    end
                end
                ST_READ: begin
                    cnt <= cnt + 1'b1;
                    if (last_rd) begin
                        ctl   <= CTL_IDLE;
                        cnt   <= '0;
                        state <= ST_RGAP;
                    end
                end
                ST_RGAP: state <= ST_IDLE;
                ST_WLOW: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(DRV_CYC - 1)) ctl.drive <= 1'b1;
                    if (cnt == CNT_W'(WEL_CYC - 1)) begin
                        ctl   <= CTL_IDLE;
                        cnt   <= '0;
                        state <= ST_WREC;
                    end
                end
                ST_WREC: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(REC_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: own drivers only inside the write-enable low window
    assert_drive_in_we_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.drive |-> !ctl.we_n);
    // R4: write strobe only with chip and output enables low
    assert_we_in_ce_R4: assert property (@(posedge clk) disable iff (rst)
        !ctl.we_n |-> (!ctl.ce_n && !ctl.oe_n));
    // R8: ready only with the memory deselected
    assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ctl.ce_n);
    // R2: the read window counter never passes its limit
    assert_read_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ) |-> (cnt < CNT_W'(RD_CYC)));

endmodule

// File: rtl/sram_ctl_path.sv
`timescale 1ns/1ps
module sram_ctl_path #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              last_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid <= last_rd;
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            if (last_rd) rd_data <= mem_dq_in;
        end
    end

    // R3: read strobe lasts one cycle
    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_NS    = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_AA_NS   = 70,
    parameter int unsigned T_PWE_NS  = 50,
    parameter int unsigned T_SD_NS   = 30,
    parameter int unsigned T_HZWE_NS = 25,
    parameter int unsigned T_AW_NS   = 60,
    parameter int unsigned T_WC_NS   = 70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned RD_CYC  = ns_to_cyc(max2(T_RC_NS, T_AA_NS), CLK_NS);
    localparam int unsigned DRV_CYC = ns_to_cyc(T_HZWE_NS, CLK_NS);
    localparam int unsigned SD_CYC  = ns_to_cyc(T_SD_NS, CLK_NS);
    localparam int unsigned WEL_CYC = max2(
        max2(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS + T_HZWE_NS, CLK_NS)),
        max2(ns_to_cyc(T_AW_NS, CLK_NS), DRV_CYC + SD_CYC));
    localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned REC_CYC = (WC_CYC > WEL_CYC + 1) ? (WC_CYC - WEL_CYC - 1) : 1;

    mem_ctl_t ctl;
    logic     accept;
    logic     last_rd;

    sram_ctl_seq #(
        .RD_CYC (RD_CYC),
        .DRV_CYC(DRV_CYC),
        .WEL_CYC(WEL_CYC),
        .REC_CYC(REC_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .last_rd  (last_rd),
        .ctl      (ctl)
    );

    sram_ctl_path #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_path (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .last_rd   (last_rd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_dq_out(mem_dq_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign mem_ce_n  = ctl.ce_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_dq_oe = ctl.drive;

    // R9: address and outgoing data hold while selected
    assert_bus_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
    // R5: drivers released on the edge that ends the write
    assert_release_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_dq_oe);
    // R5: drivers stay off on the edge the write strobe falls
    assert_no_early_drive_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> !mem_dq_oe);
    // R3: read data handed over as the memory is deselected
    assert_valid_at_deselect_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> mem_ce_n);

endmodule

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;

    localparam int CLK_NS = 8;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    sram_ctl u_sram_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;

    function automatic int bcyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int bmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int exp_rd, exp_drv, exp_wel, exp_rec;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // memory model and bench reference
    logic [DW-1:0] model [0:255];
    logic [DW-1:0] refm  [0:255];
    int rd_age = 0;
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= exp_rd - 1)
                       ? model[mem_addr[7:0]] : ~model[mem_addr[7:0]];
    always @(posedge clk) begin
        if (!mem_ce_n && mem_we_n) rd_age <= rd_age + 1;
        else rd_age <= 0;
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) model[mem_addr[7:0]] <= mem_dq_out;
    end

    // port monitor
    int ce_run, we_run, drv_run, hi_run;
    bit wrote;
    logic [AW-1:0] addr0;
    logic [DW-1:0] dat0;
    logic [DW-1:0] last_wdata;
    always @(negedge clk) begin
        if (rst) begin
            ce_run = 0; we_run = 0; drv_run = 0; hi_run = 100; wrote = 0;
        end else if (!mem_ce_n) begin
            if (ce_run == 0) begin
                chk(hi_run >= 2, "R7", "deselect gap", hi_run, 2);
                wrote = !mem_we_n;
                addr0 = mem_addr;
                dat0  = mem_dq_out;
                if (wrote) chk(mem_dq_out == last_wdata, "R6", "write data", mem_dq_out, last_wdata);
            end else begin
                chk(mem_addr == addr0, "R9", "address hold", mem_addr, addr0);
                if (wrote) chk(mem_dq_out == dat0, "R9", "data hold", mem_dq_out, dat0);
            end
            chk(!mem_oe_n, "R4", "oe low in access", mem_oe_n, 0);
            chk(mem_we_n == !wrote, "R4", "we steady", mem_we_n, !wrote);
            if (!mem_we_n) begin
                if (mem_dq_oe && drv_run == 0) chk(we_run == exp_drv, "R5", "drive delay", we_run, exp_drv);
                we_run++;
                if (mem_dq_oe) drv_run++;
            end else begin
                chk(!mem_dq_oe, "R5", "drive with we high", mem_dq_oe, 0);
            end
            ce_run++;
        end else begin
            if (ce_run != 0) begin
                if (wrote) begin
                    chk(ce_run == exp_wel, "R4", "write ce width", ce_run, exp_wel);
                    chk(we_run == exp_wel, "R4", "we width", we_run, exp_wel);
                    chk(drv_run == exp_wel - exp_drv, "R5", "drive width", drv_run, exp_wel - exp_drv);
                end else begin
                    chk(ce_run == exp_rd, "R2", "read ce width", ce_run, exp_rd);
                end
                ce_run = 0; we_run = 0; drv_run = 0; hi_run = 0;
            end
            hi_run++;
            chk(mem_oe_n && mem_we_n && !mem_dq_oe, "R5", "idle strobes",
                {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
        end
    end

    task automatic issue(input bit wr, input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_write = wr; req_addr = {8'h00, a}; req_wdata = d; req_valid = 1'b1;
        if (wr) last_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8", "ready while busy", req_ready, 0);
        req_write = $urandom; req_addr = AW'($urandom); req_wdata = DW'($urandom);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [DW-1:0] d);
        issue(1'b1, a, d);
        refm[a] = d;
    endtask

    task automatic do_read(input logic [7:0] a);
        int n;
        issue(1'b0, a, '0);
        n = 0;
        while (!rd_valid && n < 40) begin @(negedge clk); n++; end
        chk(rd_valid, "R3", "valid seen", rd_valid, 1);
        chk(mem_ce_n, "R3", "valid at deselect", mem_ce_n, 1);
        chk(rd_data == refm[a], "R3", "read data", rd_data, refm[a]);
        @(negedge clk);
        chk(!rd_valid, "R3", "single pulse", rd_valid, 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        exp_rd  = bcyc(bmax(70, 70));
        exp_drv = bcyc(25);
        exp_wel = bmax(bmax(bcyc(50), bcyc(55)), bmax(bcyc(60), bcyc(25) + bcyc(30)));
        exp_rec = bmax(1, bcyc(70) - exp_wel - 1);
        for (int i = 0; i < 256; i++) begin
            model[i] = DW'(i * 16'h0101) ^ 16'h5A5A;
            refm[i]  = DW'(i * 16'h0101) ^ 16'h5A5A;
        end
        void'($urandom(32'd4711));
        last_wdata = '0;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        chk(req_ready && !rd_valid, "R1", "host side in reset", {req_ready, rd_valid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && !mem_dq_oe && req_ready && !rd_valid, "R1", "after reset",
            {mem_ce_n, mem_dq_oe, req_ready, rd_valid}, 4'b1010);

        // R8: field changes without valid start nothing
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            req_write = $urandom; req_addr = AW'($urandom); req_wdata = DW'($urandom);
            chk(mem_ce_n && req_ready, "R8", "no valid no access", mem_ce_n, 1);
        end

        // directed corners (R2, R3, R6)
        do_read(8'h00);
        do_write(8'h00, 16'hA5C3);
        do_read(8'h00);
        do_write(8'hFF, 16'hFFFF);
        do_write(8'h01, 16'h0000);
        do_read(8'hFF);
        do_read(8'h01);
        do_write(8'h80, 16'h8001);
        do_read(8'h80);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a;
            a = 8'($urandom);
            if ($urandom % 2) do_write(a, DW'($urandom));
            else do_read(a);
        end

        // R7: write recovery plus idle is at least two cycles
        chk(exp_rec + 1 >= 2, "R7", "write recovery", exp_rec + 1, 2);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule